// File: doc/BRIEF.md
# Power-Managed Serial ADC Reader

This block is the host-side serial master for a 12-bit sampling converter whose power state is set only by how many serial clock falling edges pass before chip select is released. A one-cycle command port offers three operations. A read runs a full 16-clock frame and returns the 12-bit code. A sleep cuts the frame short inside the power-down window. A wake runs a dummy frame and then waits out the converter's power-up time.

Chip select, the serial clock and the timing of each frame come from parameters counted in system clock cycles. These parameters set the serial clock half period, the quiet gap between frames and the power-up wait. The block keeps its own view of whether the converter is powered. It refuses a read while that view is "powered down" and flags the attempt instead of starting a frame. Data is sampled on the rising serial clock edge because the converter shifts out on the falling edge.

Top module: `adc_pm_reader`

## Requirements
- R1: After reset, `cs_no` and `sclk_o` are high, `busy_o`, `valid_o` and `err_o` are low, and `powered_o` is high.
- R2: While `cs_no` is high, `sclk_o` is high. Each frame is a sequence of SCLK low/high phases of `HALF_CYC` system clocks each, preceded by a `HALF_CYC`-cycle setup after `cs_no` falls.
- R3: The op codes are 0 = read, 1 = sleep and 2 = wake. Code 3 is a no-op. A read frame gives exactly 16 SCLK falling edges. After the 16th rising edge `cs_no` rises, and `valid_o` pulses for one cycle in that same cycle.
- R4: The converter drives bit 15 of its 16-bit word on the 1st SCLK fall, bit 14 on the 2nd, and so on down to bit 0 on the 16th. `sdata_i` is sampled on each SCLK rising edge. `result_o` is bits 11:0 of the captured word.
- R5: `lead_err_o` is high with `valid_o` exactly when any of captured bits 15:12 is nonzero.
- R6: A sleep frame releases `cs_no` after `SLEEP_EDGES` falling edges (default 8). The value must lie between 2 and 9. The frame gives no `valid_o`, and `powered_o` drops at the release.
- R7: A read command while `powered_o` is low starts no frame. It pulses `err_o` for one cycle, and `busy_o` and `cs_no` stay unchanged.
- R8: A wake frame gives 16 falling edges and no `valid_o`. It is followed by `PWRUP_CYC` cycles with `busy_o` high, and `powered_o` rises at the end of that wait.
- R9: After every frame `cs_no` stays high for at least `QUIET_CYC` cycles before it can fall again. `busy_o` covers that gap.
- R10: `busy_o` is high from the cycle after accepting a command to the end of the frame, quiet gap and any power-up wait. Any command that arrives while `busy_o` is high is ignored.
- R11: With defaults `HALF_CYC`=2, `QUIET_CYC`=4 and `PWRUP_CYC`=50, `busy_o` stays high for 70 cycles per read, 38 per sleep and 120 per wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 read, 1 sleep, 2 wake, 3 no-op |
| sdata_i | input | 1 | Serial data from converter |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Command in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 12 | Conversion code |
| lead_err_o | output | 1 | Leading bits were not zero |
| err_o | output | 1 | Read refused, converter powered down |
| powered_o | output | 1 | Believed converter power state |

## Verification
A command strobed in one cycle shows up on `busy_o` and `cs_no` after the next clock edge. An `err_o` pulse is due in that same cycle. The result strobe comes `HALF_CYC*(1+2N)` cycles after that, where N is 16 for a read. `busy_o` then falls after the quiet gap, plus the power-up wait for a wake. Each scenario drives its strobe on a falling system clock edge and samples every output on falling edges, counting the cycles for which `busy_o` is high. It compares that count with the cycle totals of R11 rather than waiting for some event with an open timeout. SCLK falls are counted only while chip select is low and are checked against 16 or `SLEEP_EDGES`.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_SLEEP = 2'd1,
    OP_WAKE  = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_QUIET,
    ST_PWRUP
  } st_e;

  localparam int unsigned FRAME_EDGES = 16;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned CODE_W      = 12;
endpackage

// File: rtl/adc_pm_cnt.sv
module adc_pm_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = !clr_i && (cnt_q == lim_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/adc_pm_rx.sv
module adc_pm_rx #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              lead_nz_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (smp_i) sh_q <= {sh_q[WORD_W-2:0], sdata_i};
  end

  assign code_o    = sh_q[CODE_W-1:0];
  assign lead_nz_o = |sh_q[WORD_W-1:CODE_W];
endmodule

// File: rtl/adc_pm_fsm.sv
module adc_pm_fsm
  import adc_pm_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned QUIET_CYC   = 4,
  parameter int unsigned PWRUP_CYC   = 50,
  parameter int unsigned SLEEP_EDGES = 8,
  parameter int unsigned CW          = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic          done_i,
  output logic          cnt_clr_o,
  output logic [CW-1:0] lim_o,
  output logic          smp_o,
  output logic          cs_no,
  output logic          sclk_o,
  output logic          busy_o,
  output logic          valid_o,
  output logic          err_o,
  output logic          powered_o
);
  localparam int unsigned EW = $clog2(FRAME_EDGES + 1);

  st_e          st_q;
  op_e          op_q;
  logic [EW-1:0] edges_q;
  logic [EW-1:0] last_edge;

  assign last_edge = (op_q == OP_SLEEP) ? EW'(SLEEP_EDGES) : EW'(FRAME_EDGES);
  assign cnt_clr_o = (st_q == ST_IDLE);
  assign smp_o     = (st_q == ST_LOW) && done_i;
  assign busy_o    = (st_q != ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_SETUP, ST_LOW, ST_HIGH: lim_o = CW'(HALF_CYC);
      ST_QUIET:                  lim_o = CW'(QUIET_CYC);
      ST_PWRUP:                  lim_o = CW'(PWRUP_CYC);
      default:                   lim_o = CW'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_READ;
      edges_q   <= '0;
      cs_no     <= 1'b1;
      sclk_o    <= 1'b1;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
      powered_o <= 1'b1;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i && op_e'(cmd_op_i) != OP_NOP) begin
          if (op_e'(cmd_op_i) == OP_READ && !powered_o) begin
            err_o <= 1'b1;
          end else begin
            op_q  <= op_e'(cmd_op_i);
            cs_no <= 1'b0;
            st_q  <= ST_SETUP;
          end
        end
        ST_SETUP: if (done_i) begin
          sclk_o  <= 1'b0;
          edges_q <= EW'(1);
          st_q    <= ST_LOW;
        end
        ST_LOW: if (done_i) begin
          sclk_o <= 1'b1;
          st_q   <= ST_HIGH;
        end
        ST_HIGH: if (done_i) begin
          if (edges_q == last_edge) begin
            cs_no <= 1'b1;
            st_q  <= ST_QUIET;
            if (op_q == OP_READ)  valid_o   <= 1'b1;
            if (op_q == OP_SLEEP) powered_o <= 1'b0;
          end else begin
            sclk_o  <= 1'b0;
            edges_q <= edges_q + EW'(1);
            st_q    <= ST_LOW;
          end
        end
        ST_QUIET: if (done_i) st_q <= (op_q == OP_WAKE) ? ST_PWRUP : ST_IDLE;
        ST_PWRUP: if (done_i) begin
          powered_o <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_pm_reader.sv
module adc_pm_reader
  import adc_pm_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned QUIET_CYC   = 4,
  parameter int unsigned PWRUP_CYC   = 50,
  parameter int unsigned SLEEP_EDGES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              sdata_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [CODE_W-1:0] result_o,
  output logic              lead_err_o,
  output logic              err_o,
  output logic              powered_o
);
  localparam int unsigned MAX_A = (HALF_CYC > QUIET_CYC) ? HALF_CYC : QUIET_CYC;
  localparam int unsigned MAX_L = (MAX_A > PWRUP_CYC) ? MAX_A : PWRUP_CYC;
  localparam int unsigned CW    = $clog2(MAX_L + 1) + 1;

  logic          cnt_clr, cnt_done, smp, lead_nz;
  logic [CW-1:0] lim;

  adc_pm_cnt #(.W(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .lim_i  (lim),
    .done_o (cnt_done)
  );

  adc_pm_fsm #(
    .HALF_CYC   (HALF_CYC),
    .QUIET_CYC  (QUIET_CYC),
    .PWRUP_CYC  (PWRUP_CYC),
    .SLEEP_EDGES(SLEEP_EDGES),
    .CW         (CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (cmd_op_i),
    .done_i     (cnt_done),
    .cnt_clr_o  (cnt_clr),
    .lim_o      (lim),
    .smp_o      (smp),
    .cs_no      (cs_no),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .err_o      (err_o),
    .powered_o  (powered_o)
  );

  adc_pm_rx #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_i    (smp),
    .sdata_i  (sdata_i),
    .code_o   (result_o),
    .lead_nz_o(lead_nz)
  );

  assign lead_err_o = valid_o && lead_nz;
endmodule

// File: rtl/adc_pm_reader_chk.sv
module adc_pm_reader_chk #(
  parameter int unsigned QUIET_CYC   = 4,
  parameter int unsigned SLEEP_EDGES = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o,
  input logic err_o
);
  localparam int unsigned HW = $clog2(QUIET_CYC + 1) + 1;

  logic          cs_q, sclk_q;
  logic [4:0]    fcnt_q;
  logic [HW-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      fcnt_q <= '0;
      hcnt_q <= HW'(QUIET_CYC);
    end else begin
      cs_q   <= cs_no;
      sclk_q <= sclk_o;
      if (cs_q && !cs_no)                fcnt_q <= '0;
      else if (sclk_q && !sclk_o)        fcnt_q <= fcnt_q + 5'd1;
      if (!cs_no)                        hcnt_q <= '0;
      else if (hcnt_q < HW'(QUIET_CYC))  hcnt_q <= hcnt_q + HW'(1);
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  // R3
  valid_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!cs_q && cs_no && fcnt_q == 5'd16));

  // R6
  release_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && cs_no) |-> (fcnt_q == 5'd16 || fcnt_q == 5'(SLEEP_EDGES)));

  // R7
  err_no_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_no && !busy_o));

  // R9
  quiet_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_q && !cs_no) |-> (hcnt_q >= HW'(QUIET_CYC)));

  // R10
  idle_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
endmodule

bind adc_pm_reader adc_pm_reader_chk #(
  .QUIET_CYC  (QUIET_CYC),
  .SLEEP_EDGES(SLEEP_EDGES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_no  (cs_no),
  .sclk_o (sclk_o),
  .busy_o (busy_o),
  .valid_o(valid_o),
  .err_o  (err_o)
);

// File: tb/adc_pm_reader_bench.sv
module adc_pm_reader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        sdata = 1'b0;
  logic        cs_n, sclk, busy, valid, lead_err, err, powered;
  logic [11:0] result;

  int          n_run = 0, n_fail = 0;
  logic [15:0] word = '0;
  int          k = 0;
  int          falls = 0;

  always #10 clk = ~clk;

  adc_pm_reader #(.HALF_CYC(2), .QUIET_CYC(4), .PWRUP_CYC(50), .SLEEP_EDGES(8)) u_adc_pm_reader (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .sdata_i(sdata), .cs_no(cs_n), .sclk_o(sclk), .busy_o(busy), .valid_o(valid),
    .result_o(result), .lead_err_o(lead_err), .err_o(err), .powered_o(powered)
  );

  // converter model: bit (16-k) on the k-th falling edge
  always @(negedge cs_n) begin k = 0; sdata = 1'b0; end
  always @(negedge sclk) if (!cs_n) begin
    k = k + 1;
    falls = falls + 1;
    if (k <= 16) sdata = word[16-k];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int          b_cyc, v_cnt, e_cnt;
  logic [11:0] v_res;
  bit          v_lead;

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] w);
    word = w; falls = 0; b_cyc = 0; v_cnt = 0; e_cnt = 0; v_lead = 0; v_res = '0;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0;
    if (err) e_cnt++;
    while (busy && b_cyc < 1000) begin
      b_cyc++;
      @(negedge clk);
      if (valid) begin v_cnt++; v_res = result; v_lead = lead_err; end
    end
  endtask

  task automatic t_reset();
    check(cs_n && sclk && !busy && !valid && !err && powered, "R1 reset state",
          {cs_n, sclk, busy, valid, err, powered}, 6'b110001);
  endtask

  task automatic t_read(input logic [15:0] w);
    run_cmd(2'd0, w);
    check(falls == 16, "R3 read fall count", falls, 16);
    check(v_cnt == 1, "R3 one valid pulse", v_cnt, 1);
    check(v_res == w[11:0], "R4 result", v_res, w[11:0]);
    check(v_lead == (w[15:12] != 0), "R5 lead flag", v_lead, w[15:12] != 0);
    check(b_cyc == 70, "R11 read busy cycles", b_cyc, 70);
  endtask

  task automatic t_sleep_and_refuse();
    run_cmd(2'd1, 16'h0123);
    check(falls == 8, "R6 sleep fall count", falls, 8);
    check(v_cnt == 0, "R6 no valid on sleep", v_cnt, 0);
    check(!powered, "R6 powered dropped", powered, 0);
    check(b_cyc == 38, "R11 sleep busy cycles", b_cyc, 38);
    run_cmd(2'd0, 16'h0777);
    check(e_cnt == 1, "R7 err pulse", e_cnt, 1);
    check(b_cyc == 0 && falls == 0 && cs_n, "R7 no frame", b_cyc + falls, 0);
  endtask

  task automatic t_wake();
    run_cmd(2'd2, 16'h0ABC);
    check(falls == 16, "R8 wake fall count", falls, 16);
    check(v_cnt == 0, "R8 wake data discarded", v_cnt, 0);
    check(powered, "R8 powered restored", powered, 1);
    check(b_cyc == 120, "R11 wake busy cycles", b_cyc, 120);
  endtask

  task automatic t_busy_ignore();
    int cyc = 0;
    word = 16'h0321; falls = 0;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk); cmd_op = 2'd1;   // sleep during busy
    repeat (5) @(negedge clk);
    cmd_valid = 1'b0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
    check(powered, "R10 sleep while busy ignored", powered, 1);
    check(falls == 16, "R10 frame unchanged", falls, 16);
  endtask

  task automatic t_quiet();
    int gap = 0;
    run_cmd(2'd0, 16'h0001);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0;
    // cs_n rose at end of previous frame; busy just fell
    @(negedge clk); cmd_valid = 1'b0;
    check(!cs_n, "R9 frame restarts after quiet", cs_n, 0);
    while (busy && gap < 1000) begin gap++; @(negedge clk); end
    check(gap == 70, "R9 second frame length", gap, 70);
  endtask

  task automatic t_nop();
    run_cmd(2'd3, 16'h0000);
    check(b_cyc == 0 && falls == 0 && e_cnt == 0, "R3 nop code ignored", b_cyc + falls, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(16'h0ABC);
    t_read(16'h0FFF);
    t_read(16'h0000);
    t_read(16'h0555);
    t_read(16'h8123);
    t_read(16'h1F0F);
    t_nop();
    t_sleep_and_refuse();
    t_wake();
    t_read(16'h0A5A);
    t_busy_ignore();
    t_quiet();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule